// File: doc/BRIEF.md
# Next Program Counter Unit

This block produces the address of the next instruction for a 32-bit processor that issues one instruction per cycle. It holds the program counter. Each cycle it looks at the current instruction word, a flag from an external comparator that says whether the two source registers are equal, and the value read from the first source register. From these it picks the next address. The choices are the straight-line successor, a PC-relative conditional branch, a region-relative absolute jump, a call that also asks for a return address to be written, and an indirect jump through a register.

The register file, the equality comparator and instruction memory sit outside the block. The block returns a one-bit request to write the link register, along with the value to write into it. The register file performs that write.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset, active high, loads the program counter with the parameter RESET_VEC (default 0x0040_0000). `pc` shows RESET_VEC on the first cycle after reset is released.
- R2: When the opcode in instr[31:26] is not 0x00, 0x02, 0x03, 0x04 or 0x05, `next_pc` equals `pc` + 4. The same holds when the opcode is 0x00 and the function field instr[5:0] is not 0x08. The sum wraps modulo 2^32.
- R3: Opcode 0x04 is a branch-if-equal. When `regs_equal` is 1, `next_pc` = `pc` + 4 + (sign-extended instr[15:0] × 4). Otherwise `next_pc` = `pc` + 4.
- R4: Opcode 0x05 is a branch-if-not-equal. It takes the target of R3 when `regs_equal` is 0 and gives `pc` + 4 when `regs_equal` is 1.
- R5: The branch offset is a signed count of words. An offset of 0xFFFF lands on the branch itself. An offset of 0x8000 reaches back 0x20000 bytes from `pc` + 4. An offset of 0x7FFF reaches forward 0x1FFFC bytes.
- R6: Opcodes 0x02 (jump) and 0x03 (call) give `next_pc` = {(`pc` + 4)[31:28], instr[25:0], 2'b00}.
- R7: For opcode 0x03, `link_we` is 1 and `link_value` equals `pc` + 4. The value is meant for register 31.
- R8: Opcode 0x00 with function field 0x08 gives `next_pc` = `rs_value`, taken unchanged.
- R9: On every clock edge outside reset, `pc` takes the `next_pc` value of the previous cycle.
- R10: `link_we` is 0 for every opcode other than 0x03. This includes opcode 0x00 with function fields other than 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word at the current PC |
| regs_equal | input | 1 | 1 when the two source registers hold equal values |
| rs_value | input | 32 | Value of the first source register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address selected for the next cycle |
| link_we | output | 1 | Request to write the return address into register 31 |
| link_value | output | 32 | Return address (`pc` + 4) |

## Verification
Several rules are checked by assertions on every cycle:
- fall-through to the successor for non-control opcodes and for not-taken branches;
- the upper nibble and alignment of jump targets;
- the indirect-jump target;
- the link request being limited to the call opcode;
- the register following the previous `next_pc`.

The exact taken-branch arithmetic only shows up in the bench's scenarios: sign extension at the offset extremes, an offset landing back on the branch, wrap past the top of the address space, and jumps made from a high region reached through the indirect jump. The same holds for reset in the middle of a run.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
  localparam int XLEN   = 32;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int OFF_W  = 16;
  localparam int IDX_W  = 26;
  localparam int REGION_W = XLEN - IDX_W - 2;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OP_W-1:0] OP_JUMP    = 6'h02;
  localparam logic [OP_W-1:0] OP_CALL    = 6'h03;
  localparam logic [OP_W-1:0] OP_BR_EQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_BR_NE   = 6'h05;
  localparam logic [FN_W-1:0] FN_REG_JMP = 6'h08;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BR_EQ,
    FLOW_BR_NE,
    FLOW_JUMP,
    FLOW_CALL,
    FLOW_REG
  } flow_e;

  function automatic logic [XLEN-1:0] succ_addr(input logic [XLEN-1:0] a);
    return a + XLEN'(4);
  endfunction

  // word offset, sign extended, scaled to bytes, relative to the successor
  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] succ,
                                                 input logic [OFF_W-1:0] off);
    logic [XLEN-1:0] disp;
    disp = {{(XLEN-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return succ + disp;
  endfunction

  // region bits of the successor joined with the word index
  function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] succ,
                                                    input logic [IDX_W-1:0] idx);
    return {succ[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
`timescale 1ns/1ps
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]  instr,
  output flow_e            flow,
  output logic [OFF_W-1:0] off,
  output logic [IDX_W-1:0] idx
);
  logic [OP_W-1:0] opcode;
  logic [FN_W-1:0] fn;
  logic [XLEN-OP_W-FN_W-1:0] unused_mid;

  assign opcode = instr[XLEN-1 -: OP_W];
  assign fn     = instr[FN_W-1:0];
  assign off    = instr[OFF_W-1:0];
  assign idx    = instr[IDX_W-1:0];
  assign unused_mid = instr[XLEN-OP_W-1:FN_W];

  always_comb begin
    unique case (opcode)
      OP_BR_EQ:   flow = FLOW_BR_EQ;
      OP_BR_NE:   flow = FLOW_BR_NE;
      OP_JUMP:    flow = FLOW_JUMP;
      OP_CALL:    flow = FLOW_CALL;
      OP_SPECIAL: flow = (fn == FN_REG_JMP) ? FLOW_REG : FLOW_SEQ;
      default:    flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_select.sv
`timescale 1ns/1ps
module npc_select
  import npc_pkg::*;
(
  input  flow_e            flow,
  input  logic             regs_equal,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  rs_value,
  input  logic [OFF_W-1:0] off,
  input  logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  next_pc,
  output logic             branch_taken,
  output logic             link_we,
  output logic [XLEN-1:0]  link_value
);
  logic [XLEN-1:0] succ;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;

  assign succ    = succ_addr(pc);
  assign br_tgt  = rel_target(succ, off);
  assign jmp_tgt = region_target(succ, idx);

  assign branch_taken = ((flow == FLOW_BR_EQ) &&  regs_equal) ||
                        ((flow == FLOW_BR_NE) && !regs_equal);

  always_comb begin
    unique case (flow)
      FLOW_BR_EQ,
      FLOW_BR_NE: next_pc = branch_taken ? br_tgt : succ;
      FLOW_JUMP,
      FLOW_CALL:  next_pc = jmp_tgt;
      FLOW_REG:   next_pc = rs_value;
      default:    next_pc = succ;
    endcase
  end

  assign link_we    = (flow == FLOW_CALL);
  assign link_value = succ;
endmodule

// File: rtl/npc_pc_reg.sv
`timescale 1ns/1ps
module npc_pc_reg
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VEC;
    else     q <= d;
  end
endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
)(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic        regs_equal,
  input  logic [31:0] rs_value,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [31:0] link_value
);
  flow_e            flow;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic             branch_taken;

  npc_decode u_dec (
    .instr (instr),
    .flow  (flow),
    .off   (off),
    .idx   (idx)
  );

  npc_select u_sel (
    .flow         (flow),
    .regs_equal   (regs_equal),
    .pc           (pc),
    .rs_value     (rs_value),
    .off          (off),
    .idx          (idx),
    .next_pc      (next_pc),
    .branch_taken (branch_taken),
    .link_we      (link_we),
    .link_value   (link_value)
  );

  npc_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc (
    .clk (clk),
    .rst (rst),
    .d   (next_pc),
    .q   (pc)
  );
endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
)(
  input logic        clk,
  input logic        rst,
  input logic [5:0]  op,
  input logic [5:0]  fn,
  input logic        regs_equal,
  input logic [31:0] rs_value,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic [31:0] link_value
);
  logic        past_valid = 1'b0;
  logic [31:0] pc_plus4;
  logic        is_ctrl;

  always_ff @(posedge clk) past_valid <= 1'b1;

  assign pc_plus4 = pc + 32'd4;
  assign is_ctrl  = (op == 6'h02) || (op == 6'h03) || (op == 6'h04) ||
                    (op == 6'h05) || (op == 6'h00 && fn == 6'h08);

  p_reset_vec_r1: assert property (@(posedge clk) disable iff (rst)
    past_valid && $past(rst) |-> pc == RESET_VEC);

  p_seq_r2: assert property (@(posedge clk) disable iff (rst)
    !is_ctrl |-> next_pc == pc_plus4);

  p_beq_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && !regs_equal) |-> next_pc == pc_plus4);

  p_bne_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h05 && regs_equal) |-> next_pc == pc_plus4);

  p_jump_region_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h02 || op == 6'h03) |->
      (next_pc[31:28] == pc_plus4[31:28]) && (next_pc[1:0] == 2'b00));

  p_link_call_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h03) |-> link_we && (link_value == pc_plus4));

  p_reg_jump_r8: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h00 && fn == 6'h08) |-> next_pc == rs_value);

  p_pc_follow_r9: assert property (@(posedge clk) disable iff (rst)
    past_valid && !$past(rst) |-> pc == $past(next_pc));

  p_link_only_call_r10: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h03) |-> !link_we);
endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op         (instr[31:26]),
  .fn         (instr[5:0]),
  .regs_equal (regs_equal),
  .rs_value   (rs_value),
  .pc         (pc),
  .next_pc    (next_pc),
  .link_we    (link_we),
  .link_value (link_value)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  localparam logic [31:0] RV = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0;
  logic        regs_equal = 1'b0;
  logic [31:0] rs_value = 32'h0;
  logic [31:0] pc, next_pc, link_value;
  logic        link_we;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [31:0] model_pc;
  logic [31:0] q_pc[$];
  logic [31:0] q_nxt[$];
  logic        q_we[$];
  logic [31:0] q_lv[$];
  string       q_tag[$];
  event        item_ev;

  always #2.5 clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) u0 (
    .clk(clk), .rst(rst), .instr(instr), .regs_equal(regs_equal),
    .rs_value(rs_value), .pc(pc), .next_pc(next_pc),
    .link_we(link_we), .link_value(link_value)
  );

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd16, 5'd17, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] t);
    return {op, t};
  endfunction
  function automatic logic [31:0] enc_r(input logic [5:0] fn);
    return {6'h00, 5'd9, 5'd10, 5'd8, 5'd0, fn};
  endfunction

  // Independent model of the expected successor address
  function automatic logic [31:0] model_next(input logic [31:0] p, input logic [31:0] ins,
                                             input logic eq, input logic [31:0] rv);
    logic [31:0] s;
    logic signed [31:0] woff;
    s = p + 32'd4;
    woff = 32'(signed'(ins[15:0]));
    case (ins[31:26])
      6'h04: return eq  ? s + 32'(woff * 4) : s;
      6'h05: return !eq ? s + 32'(woff * 4) : s;
      6'h02, 6'h03: return (s & 32'hF000_0000) | ({6'b0, ins[25:0]} << 2);
      6'h00: return (ins[5:0] == 6'h08) ? rv : s;
      default: return s;
    endcase
  endfunction

  // driver: called at a falling edge, returns at the next falling edge
  task automatic apply(input logic [31:0] ins, input logic eq,
                       input logic [31:0] rv, input string tag);
    logic [31:0] exp_n;
    instr = ins; regs_equal = eq; rs_value = rv;
    exp_n = model_next(model_pc, ins, eq, rv);
    q_pc.push_back(model_pc);
    q_nxt.push_back(exp_n);
    q_we.push_back(ins[31:26] == 6'h03);
    q_lv.push_back(model_pc + 32'd4);
    q_tag.push_back(tag);
    -> item_ev;
    @(posedge clk);
    model_pc = exp_n;
    @(negedge clk);
  endtask

  // monitor: compare outputs shortly after each drive
  initial begin
    forever begin
      @(item_ev);
      #1;
      begin
        logic [31:0] e_pc, e_n, e_lv;
        logic        e_we;
        string       t;
        e_pc = q_pc.pop_front(); e_n = q_nxt.pop_front();
        e_we = q_we.pop_front(); e_lv = q_lv.pop_front(); t = q_tag.pop_front();
        check32({t, "/R9"}, "pc", pc, e_pc);
        check32(t, "next_pc", next_pc, e_n);
        check32({t, "/R10"}, "link_we", {31'b0, link_we}, {31'b0, e_we});
        if (e_we) check32({t, "/R7"}, "link_value", link_value, e_lv);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R1", "pc in reset", pc, RV);
    rst = 1'b0;
    model_pc = RV;

    apply(enc_r(6'h20), 1'b0, 32'h0, "R2");                 // register add
    apply(enc_i(6'h23, 16'h0018), 1'b1, 32'h0, "R2");       // load, eq ignored
    apply(enc_i(6'h04, 16'h0003), 1'b1, 32'h0, "R3");       // beq taken
    apply(enc_i(6'h04, 16'h0003), 1'b0, 32'h0, "R3");       // beq fall
    apply(enc_i(6'h05, 16'h0010), 1'b0, 32'h0, "R4");       // bne taken
    apply(enc_i(6'h05, 16'h0010), 1'b1, 32'h0, "R4");       // bne fall
    apply(enc_i(6'h04, 16'hFFFF), 1'b1, 32'h0, "R5");       // lands on itself
    apply(enc_i(6'h04, 16'h8000), 1'b1, 32'h0, "R5");       // farthest back
    apply(enc_i(6'h05, 16'h7FFF), 1'b0, 32'h0, "R5");       // farthest forward
    apply(enc_j(6'h02, 26'h010_0000), 1'b0, 32'h0, "R6");   // jump
    apply(enc_j(6'h03, 26'h012_3456), 1'b0, 32'h0, "R7");   // call
    apply(enc_r(6'h08), 1'b1, 32'hF000_1000, "R8");         // reg jump high
    apply(enc_j(6'h02, 26'h000_0003), 1'b0, 32'h0, "R6");   // keeps 0xF region
    apply(enc_j(6'h03, 26'h3FF_FFFF), 1'b0, 32'h0, "R7");   // call in high region
    apply(enc_r(6'h09), 1'b0, 32'h1111_1110, "R10");        // other funct: seq
    apply(enc_r(6'h08), 1'b0, 32'hFFFF_FFFC, "R8");         // to top of space
    apply(enc_r(6'h25), 1'b0, 32'h0, "R2");                 // wraps to zero
    apply(enc_i(6'h04, 16'h0002), 1'b0, 32'h0, "R3");

    // reset in the middle of a run
    rst = 1'b1; instr = enc_j(6'h02, 26'h000_0100);
    @(posedge clk);
    @(negedge clk);
    check32("R1", "pc after mid reset", pc, RV);
    rst = 1'b0;
    model_pc = RV;
    apply(enc_i(6'h05, 16'hFFFE), 1'b0, 32'h0, "R4");
    apply(enc_r(6'h00), 1'b1, 32'h0, "R2");

    #1;
    finish_run();
  end
endmodule